// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block moves whole bytes over a one-wire bus by driving a separate bit-slot engine eight times per byte. Software, or a local controller, writes a byte into the data register. The engine shifts that byte out least significant bit first, one slot at a time. During the same slots it assembles the bits sampled on the wire into a received byte, also least significant bit first.

The same data register serves both directions. To read a byte from the bus, write 0xFF: every slot is then a write-1 slot, which lets the device on the wire pull the line low. Reading the data register afterwards returns the captured byte. A write that arrives while a byte is still shifting waits in a one-entry transmit buffer and starts as soon as the shifter empties.

Four status flags report the state of the buffers: transmit buffer empty, transmit shifter empty, receive buffer full and receive shifter full. Each flag has its own enable bit. Together the flags and enables drive a single interrupt output.

Top module: `owb_byte_engine`

## Requirements
- R1: After reset the status register (select 1) reads 0x000C: bit 2 (transmit buffer empty) is 1, bit 3 (transmit shifter empty) is 1, bit 4 (receive buffer full) is 0 and bit 5 (receive shifter full) is 0. After reset the enable register reads 0, `irq` is 0 and `slot_req` is 0.
- R2: A write to select 0 stores `reg_wdata[7:0]` in the transmit buffer, and bit 2 reads 0 from the next cycle. If the shifter is empty, the byte moves into the shifter on the following edge. At that edge bit 2 returns to 1, bit 3 and bit 5 go to 0, and `slot_req` rises one cycle later.
- R3: In slot k (k = 0..7) of a transfer, `slot_val` equals bit k of the byte, so the byte goes out least significant bit first.
- R4: Once `slot_req` is high, it stays high with `slot_val` unchanged until a cycle in which `slot_done` is high. In the cycle after that accepted done, `slot_req` is low. A `slot_done` pulse while `slot_req` is low has no effect on any output or flag.
- R5: The `slot_bit` value presented with the k-th accepted done becomes bit k of the received byte.
- R6: On the edge that accepts the eighth done, bits 3, 4 and 5 all go to 1 and the received byte is copied into the receive buffer. Earlier dones change none of these flags.
- R7: Writing 0xFF makes all eight `slot_val` values 1. After the transfer, a read of select 0 returns the captured byte in bits [7:0] with bits [15:8] zero.
- R8: Asserting `reg_rd` with select 0 clears bit 4 on the next edge. If a transfer completes on that same edge, bit 4 stays set.
- R9: A write to select 0 while a transfer is in progress keeps bit 2 at 0. That byte starts on the edge after bit 3 becomes 1. A second such write before the start replaces the buffered byte.
- R10: Select 2 is the enable register. Bits [5:2] are writable and align with the status bits; every other bit reads 0. `irq` is 1 exactly when some status bit and its matching enable bit are both 1.
- R11: Writes to select 1 (status) and select 3 change nothing. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 enable, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; with select 0 it consumes the received byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| slot_req | output | 1 | Request for one bit slot, held until done |
| slot_val | output | 1 | Bit to write in the requested slot (1 also means read) |
| slot_done | input | 1 | Bit-slot engine finished the requested slot |
| slot_bit | input | 1 | Bit sampled on the wire in the finished slot |
| irq | output | 1 | OR of status bits masked by their enables |

## Verification
The assertions check the slot handshake on every cycle: the request is held with a steady bit until it is acknowledged, and it drops right after the acknowledgement. They also check that no request is open while the shifter reports empty, that a data write always leaves the transmit buffer marked full, and that the receive buffer only becomes full at the moment a shift completes. The bench's scenarios are what show the byte-level results. These include the bit order on both paths, the byte captured during a 0xFF read, the way a queued write is replaced and then started, the read-clear of the receive flag, the masking of the interrupt, and stray acknowledgements and status writes leaving everything unchanged.

// File: rtl/owb_pkg.sv
package owb_pkg;
    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_DATA = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_IEN  = 2'd2;

    // status bit positions, also the positions of the enable bits
    localparam int STS_TBE = 2;
    localparam int STS_TSE = 3;
    localparam int STS_RBF = 4;
    localparam int STS_RSF = 5;
    localparam int STS_LO  = STS_TBE;
    localparam int STS_N   = 4;

    typedef struct packed {
        logic tbe;
        logic tse;
        logic rbf;
        logic rsf;
    } flags_t;
endpackage

// File: rtl/owb_txbuf.sv
module owb_txbuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        // a write in the same cycle as a hand-off refills the buffer
        if (wr_en) begin
            st_d.full = 1'b1;
            st_d.data = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;
endmodule

// File: rtl/owb_shifter.sv
module owb_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_byte,
    output logic              take,
    output logic              slot_req,
    output logic              slot_val,
    input  logic              slot_done,
    input  logic              slot_bit,
    output logic              idle,
    output logic              rsf,
    output logic              xfer_done,
    output logic [BYTE_W-1:0] rx_new
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              busy;
        logic              req;
        logic              rsf;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] tx_sh;
        logic [BYTE_W-1:0] rx_sh;
    } st_t;

    st_t  st_d, st_q;
    logic take_w;
    logic done_w;

    assign take_w = !st_q.busy && buf_full;

    always_comb begin
        st_d   = st_q;
        done_w = 1'b0;
        if (take_w) begin
            st_d.busy  = 1'b1;
            st_d.req   = 1'b0;
            st_d.rsf   = 1'b0;
            st_d.cnt   = '0;
            st_d.tx_sh = buf_byte;
            st_d.rx_sh = '0;
        end else if (st_q.busy) begin
            if (st_q.req && slot_done) begin
                // LSB first: shift right, new bit enters at the top
                st_d.rx_sh = {slot_bit, st_q.rx_sh[BYTE_W-1:1]};
                st_d.tx_sh = {1'b0, st_q.tx_sh[BYTE_W-1:1]};
                st_d.req   = 1'b0;
                if (st_q.cnt == LAST) begin
                    st_d.busy = 1'b0;
                    st_d.rsf  = 1'b1;
                    done_w    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (!st_q.req) begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take      = take_w;
    assign slot_req  = st_q.req;
    assign slot_val  = st_q.tx_sh[0];
    assign idle      = !st_q.busy;
    assign rsf       = st_q.rsf;
    assign xfer_done = done_w;
    assign rx_new    = st_d.rx_sh;
endmodule

// File: rtl/owb_status.sv
module owb_status
    import owb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] rx_new,
    input  logic              rd_clr,
    input  logic              ien_wr,
    input  logic [STS_N-1:0]  ien_wdata,
    input  logic              tbe,
    input  logic              tse,
    input  logic              rsf,
    output logic              rbf,
    output logic [BYTE_W-1:0] rx_buf,
    output logic [STS_N-1:0]  ien,
    output flags_t            flags,
    output logic              irq
);
    typedef struct packed {
        logic              rbf;
        logic [BYTE_W-1:0] rx_buf;
        logic [STS_N-1:0]  ien;
    } st_t;

    st_t            st_d, st_q;
    logic [STS_N-1:0] sts_vec;

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.rbf = 1'b0;
        end
        // completion wins over a same-cycle read clear
        if (xfer_done) begin
            st_d.rbf    = 1'b1;
            st_d.rx_buf = rx_new;
        end
        if (ien_wr) begin
            st_d.ien = ien_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags.tbe = tbe;
        flags.tse = tse;
        flags.rbf = st_q.rbf;
        flags.rsf = rsf;
        sts_vec   = {rsf, st_q.rbf, tse, tbe};
    end

    assign irq    = |(sts_vec & st_q.ien);
    assign rbf    = st_q.rbf;
    assign rx_buf = st_q.rx_buf;
    assign ien    = st_q.ien;
endmodule

// File: rtl/owb_byte_engine.sv
module owb_byte_engine
    import owb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int REG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             slot_req,
    output logic             slot_val,
    input  logic             slot_done,
    input  logic             slot_bit,
    output logic             irq
);
    logic              wr_data, wr_ien, rd_data;
    logic              buf_full, take, tse, rsf, xfer_done, rbf;
    logic              st_tbe, st_tse, st_rbf, st_rsf;
    logic [BYTE_W-1:0] buf_byte, rx_new, rx_buf;
    logic [STS_N-1:0]  ien;
    flags_t            flags;
    logic              unused_hi;

    assign wr_data = reg_wr && (reg_sel == SEL_DATA);
    assign wr_ien  = reg_wr && (reg_sel == SEL_IEN);
    assign rd_data = reg_rd && (reg_sel == SEL_DATA);

    owb_txbuf #(.BYTE_W(BYTE_W)) txbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_data),
        .wr_byte (reg_wdata[BYTE_W-1:0]),
        .take    (take),
        .full    (buf_full),
        .data    (buf_byte)
    );

    owb_shifter #(.BYTE_W(BYTE_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_full  (buf_full),
        .buf_byte  (buf_byte),
        .take      (take),
        .slot_req  (slot_req),
        .slot_val  (slot_val),
        .slot_done (slot_done),
        .slot_bit  (slot_bit),
        .idle      (tse),
        .rsf       (rsf),
        .xfer_done (xfer_done),
        .rx_new    (rx_new)
    );

    owb_status #(.BYTE_W(BYTE_W)) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_done (xfer_done),
        .rx_new    (rx_new),
        .rd_clr    (rd_data),
        .ien_wr    (wr_ien),
        .ien_wdata (reg_wdata[STS_LO +: STS_N]),
        .tbe       (!buf_full),
        .tse       (tse),
        .rsf       (rsf),
        .rbf       (rbf),
        .rx_buf    (rx_buf),
        .ien       (ien),
        .flags     (flags),
        .irq       (irq)
    );

    assign st_tbe = flags.tbe;
    assign st_tse = flags.tse;
    assign st_rbf = flags.rbf;
    assign st_rsf = flags.rsf;
    assign unused_hi = ^{reg_wdata, rbf};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_DATA: reg_rdata[BYTE_W-1:0] = rx_buf;
            SEL_STAT: begin
                reg_rdata[STS_TBE] = st_tbe;
                reg_rdata[STS_TSE] = st_tse;
                reg_rdata[STS_RBF] = st_rbf;
                reg_rdata[STS_RSF] = st_rsf;
            end
            SEL_IEN:  reg_rdata[STS_LO +: STS_N] = ien;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/owb_byte_engine_chk.sv
module owb_byte_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic       slot_req,
    input logic       slot_val,
    input logic       slot_done,
    input logic       st_tbe,
    input logic       st_tse,
    input logic       st_rbf,
    input logic       st_rsf
);
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_done) |=> (slot_req && $stable(slot_val)));

    assert_req_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && slot_done) |=> !slot_req);

    assert_idle_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_tse |-> !slot_req);

    assert_wr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> !st_tbe);

    assert_rbf_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_rbf) |-> (st_tse && st_rsf));
endmodule

bind owb_byte_engine owb_byte_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .slot_req  (slot_req),
    .slot_val  (slot_val),
    .slot_done (slot_done),
    .st_tbe    (st_tbe),
    .st_tse    (st_tse),
    .st_rbf    (st_rbf),
    .st_rsf    (st_rsf)
);

// File: tb/owb_byte_engine_tb_top.sv
module owb_byte_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        slot_req, slot_val, irq;
    logic        slot_done = 1'b0;
    logic        slot_bit = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    owb_byte_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_req(slot_req), .slot_val(slot_val), .slot_done(slot_done),
        .slot_bit(slot_bit), .irq(irq)
    );

    // behavioural reference model
    int m_tbe, m_busy, m_req, m_rsf, m_rbf, m_cnt, m_ien;
    int m_txbuf, m_sh, m_rx, m_rxbuf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tbe = 1; m_busy = 0; m_req = 0; m_rsf = 0; m_rbf = 0; m_cnt = 0;
            m_ien = 0; m_txbuf = 0; m_sh = 0; m_rx = 0; m_rxbuf = 0;
        end else begin
            int n_tbe, n_txbuf, fin;
            n_tbe = m_tbe; n_txbuf = m_txbuf; fin = 0;
            if (m_busy == 0 && m_tbe == 0) begin
                n_tbe = 1;
                m_busy = 1; m_cnt = 0; m_req = 0; m_rsf = 0;
                m_sh = m_txbuf; m_rx = 0;
            end else if (m_busy != 0) begin
                if (m_req != 0 && slot_done) begin
                    m_rx = m_rx | (int'(slot_bit) << m_cnt);
                    m_sh = m_sh / 2;
                    m_req = 0;
                    m_cnt = m_cnt + 1;
                    if (m_cnt == 8) begin
                        m_busy = 0; m_rsf = 1; fin = 1;
                    end
                end else if (m_req == 0) begin
                    m_req = 1;
                end
            end
            if (reg_wr && reg_sel == 2'd0) begin
                n_tbe = 0; n_txbuf = reg_wdata & 16'hFF;
            end
            if (reg_rd && reg_sel == 2'd0) m_rbf = 0;
            if (fin != 0) begin m_rbf = 1; m_rxbuf = m_rx; end
            if (reg_wr && reg_sel == 2'd2) m_ien = (reg_wdata >> 2) & 4'hF;
            m_tbe = n_tbe; m_txbuf = n_txbuf;
        end
    end

    function automatic int m_status();
        return (m_rsf << 5) | (m_rbf << 4) | ((m_busy == 0 ? 1 : 0) << 3) | (m_tbe << 2);
    endfunction

    function automatic int m_rdata(logic [1:0] s);
        case (s)
            2'd0: return m_rxbuf;
            2'd1: return m_status();
            2'd2: return m_ien << 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // bit-slot engine stand-in
    int dly = 1, wcnt = 0, ridx = 0, spur = 0;
    logic [7:0] pat = 8'hFF;

    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk("R4 slot_req", int'(slot_req), m_req);
            chk("R3 slot_val", int'(slot_val), m_sh & 1);
            chk("R11 reg_rdata", int'(reg_rdata), m_rdata(reg_sel));
            chk("R10 irq", int'(irq), ((m_ien & (m_status() >> 2)) != 0) ? 1 : 0);
        end
        if (spur != 0) begin
            slot_done = 1'b1; slot_bit = 1'b1; spur = 0;
        end else if (slot_done) begin
            slot_done = 1'b0;
        end else if (slot_req) begin
            if (wcnt >= dly) begin
                slot_done = 1'b1;
                slot_bit = slot_val ? pat[ridx] : 1'b0;
                ridx = (ridx + 1) % 8;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [15:0] v);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            step();
            if (m_busy == 0 && m_tbe == 1) break;
        end
        step();
    endtask

    initial begin
        fork
            begin : main_seq
                logic [15:0] v;
                repeat (3) step();
                rst_n = 1'b1;
                step();
                // R1 reset state
                rd(2'd1, v); chk("R1 status", int'(v), 16'h000C);
                rd(2'd2, v); chk("R1 enable", int'(v), 0);
                chk("R1 irq", int'(irq), 0);
                chk("R1 slot_req", int'(slot_req), 0);

                // R10 enable register width and irq masking
                wr(2'd2, 16'hFFFF);
                rd(2'd2, v); chk("R10 enable bits", int'(v), 16'h003C);
                chk("R10 irq on", int'(irq), 1);
                wr(2'd2, 16'h0010);
                step();
                chk("R10 irq masked", int'(irq), 0);

                // R2 R3 R5: transmit 0xA5 with a line that reads back written bits
                pat = 8'hFF; ridx = 0; dly = 2;
                wr(2'd0, 16'h00A5);
                rd(2'd1, v); chk("R2 tbe cleared", int'(v[2]), 0);
                wait_idle();
                rd(2'd1, v); chk("R6 flags after byte", int'(v), 16'h003C);
                chk("R10 irq rbf", int'(irq), 1);
                rd(2'd0, v); chk("R5 rx byte", int'(v), 16'h00A5);
                rd(2'd1, v); chk("R8 rbf cleared", int'(v[4]), 0);

                // R7 read by writing 0xFF
                pat = 8'h3C; ridx = 0; dly = 0;
                wr(2'd0, 16'hFFFF);
                wait_idle();
                rd(2'd0, v); chk("R7 read byte", int'(v), 16'h003C);

                // R9 queued write, replaced before start
                pat = 8'hFF; ridx = 0; dly = 1;
                wr(2'd0, 16'h0012);
                repeat (4) step();
                wr(2'd0, 16'h0034);
                rd(2'd1, v); chk("R9 tbe held", int'(v[2]), 0);
                wr(2'd0, 16'h0056);
                wait_idle();
                rd(2'd0, v); chk("R9 replaced byte", int'(v), 16'h0056);

                // R4 stray done while idle
                spur = 1;
                step(); step(); step();
                rd(2'd1, v); chk("R4 stray done", int'(v), 16'h002C);
                chk("R4 no req", int'(slot_req), 0);

                // R11 status and select 3 writes ignored
                wr(2'd1, 16'hFFFF);
                wr(2'd3, 16'hFFFF);
                rd(2'd1, v); chk("R11 status unchanged", int'(v), 16'h002C);
                rd(2'd2, v); chk("R11 enable unchanged", int'(v), 16'h0010);
                rd(2'd3, v); chk("R11 sel3 zero", int'(v), 0);

                // R8 overrun keeps last byte, rbf stays set
                pat = 8'h00; ridx = 0; dly = 3;
                wr(2'd0, 16'h00F0);
                wait_idle();
                wr(2'd0, 16'h0081);
                wait_idle();
                rd(2'd1, v); chk("R8 rbf set", int'(v[4]), 1);
                rd(2'd0, v); chk("R5 last byte", int'(v), 16'h0000);
                step();
            end
            begin : watchdog
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule